// File: doc/BRIEF.md
# Push-Button Power Mode Controller

This block sequences the operating mode of a power-management device. It watches an active-low push button, an active-low external reset pin, a power-enable level from the host processor, a fault flag and two control bits. From these it drives three outputs: an enable for the always-on regulator, a single enable for all remaining rails, and a power-good flag. A 3-bit output reports the current mode.

A falling edge on the button wakes the device from OFF or SLEEP into a wait state. In that state only the always-on regulator runs while the controller waits for the host to raise power-enable. If power-enable rises, the device becomes ACTIVE. If it does not rise before a timeout, the device drops back to OFF.

Several events leave ACTIVE:

- Dropping power-enable shuts the device down. It ends in full OFF or in a retention SLEEP mode, as a control bit selects.
- Holding the button down for the long-press time power-cycles the device through RESET. A button that stays held repeats this cycle.
- The external reset pin forces RESET from any mode. The device then holds all rails off for a minimum time.

Shutdowns normally pass through a timed power-down step. Power-good and the main rails drop first, and the always-on regulator drops after a delay. A fast-off control bit skips this step. A fault during the step ends in OFF.

All timing comes from one millisecond prescaler parameter, so a test build can shrink every interval.

Top module: `pb_power_ctrl`

## Requirements
- R1: After the module reset, the mode code is OFF and the always-on enable, rail enable and power-good outputs are all low. The mode codes are OFF=0, SLEEP=1, WAIT=2, ACTIVE=3, POWER_DOWN=4 and RESET=5.
- R2: A falling edge on the synchronized button in OFF or SLEEP moves the mode to WAIT. In WAIT the always-on enable is high, and the rail enable and power-good are low.
- R3: In WAIT, a high power-enable moves the mode to ACTIVE on the next clock. In ACTIVE the always-on enable, rail enable and power-good are all high.
- R4: A WAIT entered from OFF or SLEEP that lasts PWREN_TO_MS without power-enable ends in OFF. The mode holds WAIT for exactly PWREN_TO_MS*CYC_PER_MS+1 clocks.
- R5: A low power-enable in ACTIVE shuts the device down. The shutdown ends in OFF when the full-off bit is 1. It ends in SLEEP when the full-off bit is 0, and in SLEEP only the always-on enable stays high.
- R6: A shutdown without fast-off enters POWER_DOWN. On entry, power-good and the rail enable fall while the always-on enable stays high. The mode leaves POWER_DOWN after exactly PD_SEQ_MS*CYC_PER_MS+1 clocks.
- R7: With the fast-off bit at 1, a shutdown from ACTIVE goes straight to its end mode without visiting POWER_DOWN.
- R8: A high fault input during POWER_DOWN sends the mode to OFF on the next clock, whatever the planned end mode.
- R9: A button held low for LONG_PRESS_MS in ACTIVE starts a shutdown whose end mode is RESET. From RESET the device returns through WAIT toward ACTIVE.
- R10: The long-press timer restarts while in RESET. A button that stays held therefore re-enters the power-down toward RESET exactly LONG_PRESS_MS*CYC_PER_MS clocks after ACTIVE is re-entered from a one-clock WAIT.
- R11: A low synchronized external reset forces RESET from any mode, with all three outputs low. RESET lasts until the pin is high and at least RST_MIN_MS has passed, which is exactly RST_MIN_MS*CYC_PER_MS+1 clocks when the pin is released early.
- R12: On leaving RESET the mode enters WAIT. If power-enable is high, the mode reaches ACTIVE on the next clock. Otherwise it falls to OFF after OFF_WAIT_MS, which is OFF_WAIT_MS*CYC_PER_MS+1 clocks.
- R13: The outputs change only on the clock where the mode changes. A short button press in ACTIVE changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| pb_n | input | 1 | Push button, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pwr_en | input | 1 | Host power-enable level, synchronous |
| fault | input | 1 | Supply fault flag, synchronous |
| cfg_full_off | input | 1 | 1: shutdown ends in OFF, 0: ends in SLEEP |
| cfg_fast_off | input | 1 | 1: skip the timed power-down step |
| aon_en | output | 1 | Always-on regulator enable |
| rails_en | output | 1 | Enable for all other rails |
| pgood | output | 1 | Power-good flag |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the controller with CYC_PER_MS=2, LONG_PRESS_MS=40, PWREN_TO_MS=25, RST_MIN_MS=10, OFF_WAIT_MS=10 and PD_SEQ_MS=5. With these values every interval lasts tens of clocks instead of millions. As a result, the exact dwell of each mode can be checked clock for clock, and repeated long-press cycles fit in a short run. The two wait limits differ, 25 ms against 10 ms, so the bench can tell the reset-exit timeout from the wake-up timeout. The long press is longer than the reset hold plus the power-down step, so a held button cycles visibly more than once.

// File: rtl/pbpc_pkg.sv
package pbpc_pkg;
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_DOWN   = 3'd4,
        ST_RESET  = 3'd5
    } pwr_mode_e;
endpackage

// File: rtl/pbpc_sync.sv
module pbpc_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {STAGES{INIT}};
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pbpc_mstimer.sv
module pbpc_mstimer #(
    parameter int CYC_PER_MS = 1000,
    parameter int MS_W       = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [MS_W-1:0] ms
);
    localparam int CYC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_MS - 1);

    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            ms  <= '0;
        end else if (clr) begin
            cyc <= '0;
            ms  <= '0;
        end else if (cyc == CYC_LAST) begin
            cyc <= '0;
            if (ms != '1) ms <= ms + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    // R4: elapsed time never steps backwards unless restarted
    ms_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ms >= $past(ms));
endmodule

// File: rtl/pbpc_fsm.sv
module pbpc_fsm
    import pbpc_pkg::*;
#(
    parameter int MS_W          = 14,
    parameter int LONG_PRESS_MS = 8000,
    parameter int PWREN_TO_MS   = 5000,
    parameter int RST_MIN_MS    = 1000,
    parameter int OFF_WAIT_MS   = 1000,
    parameter int PD_SEQ_MS     = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pb_s,
    input  logic            xr_s,
    input  logic            pwr_en,
    input  logic            fault,
    input  logic            full_off,
    input  logic            fast_off,
    input  logic [MS_W-1:0] st_ms,
    input  logic [MS_W-1:0] pr_ms,
    output logic            st_clr,
    output logic            pr_clr,
    output pwr_mode_e       mode,
    output logic            aon_q,
    output logic            rails_q,
    output logic            pgood_q
);
    localparam logic [MS_W-1:0] LONG_LIM = MS_W'(LONG_PRESS_MS);
    localparam logic [MS_W-1:0] PWREN_LIM = MS_W'(PWREN_TO_MS);
    localparam logic [MS_W-1:0] RST_LIM = MS_W'(RST_MIN_MS);
    localparam logic [MS_W-1:0] OFFW_LIM = MS_W'(OFF_WAIT_MS);
    localparam logic [MS_W-1:0] PD_LIM = MS_W'(PD_SEQ_MS);

    pwr_mode_e       nx, tgt_q, tgt_d;
    logic            pb_d, from_rst_q;
    logic            pb_fall, long_hit;
    logic [MS_W-1:0] wait_lim;

    assign pb_fall  = pb_d & ~pb_s;
    assign long_hit = (pr_ms >= LONG_LIM);
    assign wait_lim = from_rst_q ? OFFW_LIM : PWREN_LIM;
    assign st_clr   = (nx != mode);
    assign pr_clr   = pb_s | (mode == ST_RESET);

    always_comb begin
        nx    = mode;
        tgt_d = tgt_q;
        if (!xr_s && mode != ST_RESET) begin
            nx = ST_RESET;
        end else begin
            unique case (mode)
                ST_OFF, ST_SLEEP: begin
                    if (pb_fall) nx = ST_WAIT;
                end
                ST_WAIT: begin
                    if (pwr_en)                nx = ST_ACTIVE;
                    else if (st_ms >= wait_lim) nx = ST_OFF;
                end
                ST_ACTIVE: begin
                    if (long_hit) begin
                        tgt_d = ST_RESET;
                        nx    = fast_off ? ST_RESET : ST_DOWN;
                    end else if (!pwr_en) begin
                        tgt_d = full_off ? ST_OFF : ST_SLEEP;
                        nx    = fast_off ? tgt_d : ST_DOWN;
                    end
                end
                ST_DOWN: begin
                    if (fault)                nx = ST_OFF;
                    else if (st_ms >= PD_LIM) nx = tgt_q;
                end
                ST_RESET: begin
                    if (xr_s && st_ms >= RST_LIM) nx = ST_WAIT;
                end
                default: nx = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode       <= ST_OFF;
            tgt_q      <= ST_OFF;
            pb_d       <= 1'b1;
            from_rst_q <= 1'b0;
        end else begin
            mode  <= nx;
            tgt_q <= tgt_d;
            pb_d  <= pb_s;
            if (nx == ST_WAIT && mode != ST_WAIT) from_rst_q <= (mode == ST_RESET);
        end
    end

    // outputs, loaded from the next mode so they move with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aon_q   <= 1'b0;
            rails_q <= 1'b0;
            pgood_q <= 1'b0;
        end else begin
            unique case (nx)
                ST_ACTIVE: begin
                    aon_q   <= 1'b1;
                    rails_q <= 1'b1;
                    pgood_q <= 1'b1;
                end
                ST_SLEEP, ST_WAIT, ST_DOWN: begin
                    aon_q   <= 1'b1;
                    rails_q <= 1'b0;
                    pgood_q <= 1'b0;
                end
                default: begin
                    aon_q   <= 1'b0;
                    rails_q <= 1'b0;
                    pgood_q <= 1'b0;
                end
            endcase
        end
    end

    // R2
    wait_aon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_WAIT) |-> (aon_q && !rails_q && !pgood_q));

    // R11
    reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_RESET) |-> (!aon_q && !rails_q && !pgood_q));

    // R13
    out_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == $past(mode)) |-> ($stable(aon_q) && $stable(rails_q) && $stable(pgood_q)));

    // R6
    pgood_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(aon_q) && $past(mode) == ST_DOWN) |-> $past(!pgood_q && !rails_q));
endmodule

// File: rtl/pb_power_ctrl.sv
module pb_power_ctrl
    import pbpc_pkg::*;
#(
    parameter int CYC_PER_MS    = 1000,
    parameter int LONG_PRESS_MS = 8000,
    parameter int PWREN_TO_MS   = 5000,
    parameter int RST_MIN_MS    = 1000,
    parameter int OFF_WAIT_MS   = 1000,
    parameter int PD_SEQ_MS     = 11,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pb_n,
    input  logic       ext_rst_n,
    input  logic       pwr_en,
    input  logic       fault,
    input  logic       cfg_full_off,
    input  logic       cfg_fast_off,
    output logic       aon_en,
    output logic       rails_en,
    output logic       pgood,
    output logic [2:0] mode_o
);
    localparam int MAX_A  = (LONG_PRESS_MS > PWREN_TO_MS) ? LONG_PRESS_MS : PWREN_TO_MS;
    localparam int MAX_B  = (RST_MIN_MS > OFF_WAIT_MS) ? RST_MIN_MS : OFF_WAIT_MS;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_MS = (MAX_C > PD_SEQ_MS) ? MAX_C : PD_SEQ_MS;
    localparam int MS_W   = $clog2(MAX_MS + 2);
    localparam int N_TMR  = 2;

    logic                  pb_s, xr_s;
    logic                  st_clr, pr_clr;
    logic [N_TMR-1:0]      tmr_clr;
    logic [MS_W-1:0]       tmr_ms [N_TMR];
    pwr_mode_e             mode;

    pbpc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_pb (
        .clk(clk), .rst_n(rst_n), .d(pb_n), .q(pb_s));

    pbpc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_xr (
        .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(xr_s));

    assign tmr_clr = {pr_clr, st_clr};

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        pbpc_mstimer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .clr(tmr_clr[i]), .ms(tmr_ms[i]));
    end

    pbpc_fsm #(
        .MS_W(MS_W), .LONG_PRESS_MS(LONG_PRESS_MS), .PWREN_TO_MS(PWREN_TO_MS),
        .RST_MIN_MS(RST_MIN_MS), .OFF_WAIT_MS(OFF_WAIT_MS), .PD_SEQ_MS(PD_SEQ_MS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pb_s(pb_s), .xr_s(xr_s), .pwr_en(pwr_en),
        .fault(fault), .full_off(cfg_full_off), .fast_off(cfg_fast_off),
        .st_ms(tmr_ms[0]), .pr_ms(tmr_ms[1]), .st_clr(st_clr), .pr_clr(pr_clr),
        .mode(mode), .aon_q(aon_en), .rails_q(rails_en), .pgood_q(pgood));

    assign mode_o = mode;
endmodule

// File: tb/pb_power_ctrl_test.sv
module pb_power_ctrl_test;
    localparam int CPM = 2;
    localparam int ANY = 1000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pb_n = 1'b1, ext_rst_n = 1'b1, pwr_en = 1'b0, fault = 1'b0;
    logic cfg_full_off = 1'b0, cfg_fast_off = 1'b0;
    logic aon_en, rails_en, pgood;
    logic [2:0] mode_o;

    int n_vec = 0, n_bad = 0, cyc = 0, dwell = 0;
    logic [2:0] last_mode = 3'd0;
    bit mon_en = 1'b0, done = 1'b0;

    logic [5:0] q_exp[$];
    int q_min[$], q_max[$];
    string q_tag[$];

    always #4 clk = ~clk;

    pb_power_ctrl #(.CYC_PER_MS(CPM), .LONG_PRESS_MS(40), .PWREN_TO_MS(25),
        .RST_MIN_MS(10), .OFF_WAIT_MS(10), .PD_SEQ_MS(5)) uut (
        .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .ext_rst_n(ext_rst_n),
        .pwr_en(pwr_en), .fault(fault), .cfg_full_off(cfg_full_off),
        .cfg_fast_off(cfg_fast_off), .aon_en(aon_en), .rails_en(rails_en),
        .pgood(pgood), .mode_o(mode_o));

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_mode(input logic [2:0] m, input logic a, input logic r,
                               input logic g, input int dmin, input int dmax,
                               input string tag);
        q_exp.push_back({m, a, r, g});
        q_min.push_back(dmin);
        q_max.push_back(dmax);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        while (q_exp.size() != 0) @(negedge clk);
    endtask

    task automatic press(input int n);
        pb_n = 1'b0;
        repeat (n) @(negedge clk);
        pb_n = 1'b1;
    endtask

    // monitor: compare each mode change against the queue
    always @(negedge clk) begin
        if (mon_en) begin
            if (mode_o !== last_mode) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R13", "unexpected mode change", int'(mode_o), int'(last_mode));
                end else begin
                    logic [5:0] e;
                    int mn, mx;
                    string t;
                    e = q_exp.pop_front(); mn = q_min.pop_front();
                    mx = q_max.pop_front(); t = q_tag.pop_front();
                    check({mode_o, aon_en, rails_en, pgood} === e, t, "mode+outputs",
                          int'({mode_o, aon_en, rails_en, pgood}), int'(e));
                    if (mx != ANY || mn != 0)
                        check(dwell >= mn && dwell <= mx, t, "dwell of previous mode", dwell, mn);
                end
                last_mode = mode_o;
                dwell = 1;
            end else begin
                dwell++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            check(1'b0, "R1", "watchdog expired", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode_o == 3'd0 && !aon_en && !rails_en && !pgood, "R1", "reset state",
              int'({mode_o, aon_en, rails_en, pgood}), 0);
        mon_en = 1'b1;

        // R2 / R4: wake from OFF, no power-enable, timeout back to OFF
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd0, 0, 0, 0, 25*CPM+1, 25*CPM+1, "R4");
        press(4);
        drain();

        // R3: wake with power-enable high
        pwr_en = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R3");
        press(4);
        drain();

        // R13: short press in ACTIVE has no effect
        press(5);
        repeat (40) @(negedge clk);
        check(mode_o == 3'd3 && aon_en && rails_en && pgood, "R13", "short press ignored",
              int'(mode_o), 3);

        // R5 / R6: shutdown to SLEEP through POWER_DOWN
        cfg_full_off = 1'b0;
        expect_mode(3'd4, 1, 0, 0, 0, ANY, "R6");
        expect_mode(3'd1, 1, 0, 0, 5*CPM+1, 5*CPM+1, "R5");
        pwr_en = 1'b0;
        drain();

        // R2: wake from SLEEP
        pwr_en = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R3");
        press(4);
        drain();

        // R5 / R6: shutdown to OFF, always-on drops after the delay
        cfg_full_off = 1'b1;
        expect_mode(3'd4, 1, 0, 0, 0, ANY, "R6");
        expect_mode(3'd0, 0, 0, 0, 5*CPM+1, 5*CPM+1, "R6");
        pwr_en = 1'b0;
        drain();

        // R7: fast-off skips POWER_DOWN
        pwr_en = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R3");
        press(4);
        drain();
        cfg_fast_off = 1'b1;
        expect_mode(3'd0, 0, 0, 0, 0, ANY, "R7");
        pwr_en = 1'b0;
        drain();
        cfg_fast_off = 1'b0;

        // R8: fault during POWER_DOWN ends in OFF, not SLEEP
        pwr_en = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R3");
        press(4);
        drain();
        cfg_full_off = 1'b0;
        expect_mode(3'd4, 1, 0, 0, 0, ANY, "R6");
        expect_mode(3'd0, 0, 0, 0, 1, 5*CPM, "R8");
        pwr_en = 1'b0;
        while (q_exp.size() > 1) @(negedge clk);
        repeat (3) @(negedge clk);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        drain();

        // R9 / R10: long press power-cycles, held press repeats
        pwr_en = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 0, ANY, "R2");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R3");
        expect_mode(3'd4, 1, 0, 0, 0, ANY, "R9");
        expect_mode(3'd5, 0, 0, 0, 5*CPM+1, 5*CPM+1, "R9");
        expect_mode(3'd2, 1, 0, 0, 10*CPM+1, 10*CPM+1, "R9");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R10");
        expect_mode(3'd4, 1, 0, 0, 40*CPM, 40*CPM, "R10");
        expect_mode(3'd5, 0, 0, 0, 5*CPM+1, 5*CPM+1, "R10");
        pb_n = 1'b0;
        drain();
        pb_n = 1'b1;
        expect_mode(3'd2, 1, 0, 0, 10*CPM+1, 10*CPM+1, "R12");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R12");
        drain();

        // R11: short external reset pulse, minimum hold applies
        expect_mode(3'd5, 0, 0, 0, 0, ANY, "R11");
        expect_mode(3'd2, 1, 0, 0, 10*CPM+1, 10*CPM+1, "R11");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R12");
        ext_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        drain();

        // R11: long external reset holds RESET while low
        expect_mode(3'd5, 0, 0, 0, 0, ANY, "R11");
        expect_mode(3'd2, 1, 0, 0, 38, 44, "R11");
        expect_mode(3'd3, 1, 1, 1, 1, 1, "R12");
        ext_rst_n = 1'b0;
        repeat (40) @(negedge clk);
        ext_rst_n = 1'b1;
        drain();

        // R12: leaving RESET without power-enable falls to OFF after the short wait
        expect_mode(3'd5, 0, 0, 0, 0, ANY, "R11");
        expect_mode(3'd2, 1, 0, 0, 10*CPM+1, 10*CPM+1, "R12");
        expect_mode(3'd0, 0, 0, 0, 10*CPM+1, 10*CPM+1, "R12");
        ext_rst_n = 1'b0;
        while (q_exp.size() > 2) @(negedge clk);
        pwr_en = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        drain();

        repeat (10) @(negedge clk);
        check(q_exp.size() == 0 && mode_o == 3'd0, "R12", "final mode OFF",
              int'(mode_o), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule